// File: doc/BRIEF.md
# Paired Micro-Op Dispatch Controller

This controller sits between a micro-op queue and the execution back end of a vector unit. Each cycle it looks at the two micro-ops at the head of the queue, called slot 0 (older) and slot 1 (younger). It decides which of them leave this cycle. A micro-op that leaves is handed to one of five execution queues (ALU, permute/reduce, multiply, divide, load/store) and to the reorder buffer. All of these transfers are valid/ready handshakes. The controller moves no operand data. It only makes the issue decision, steers the valid bits, assigns reorder-buffer addresses and forms the destination record for the reorder buffer.

Upstream logic compares each slot's sources against the reorder buffer and reports the result as a per-slot pending-dependency flag. The controller does the checks inside the pair itself: a read-after-write between the two slots, and a budget of four register-file read ports shared by both slots. A slot that is not dispatched gets no ready, so it stays at the head of the queue and is offered again next cycle.

Top module: `pair_dispatch`

## Requirements
- R1: Slot 1 is dispatched only in a cycle where slot 0 is also dispatched, so at most two micro-ops leave per cycle and they leave in order.
- R2: Slot 0 is not dispatched while its pending-dependency flag is set or its queue valid is low.
- R3: Slot 1 is not dispatched while its pending-dependency flag is set.
- R4: Slot 1 is held when it reads a register that slot 0 writes as a vector destination. Slot 1's reads are vs1, vs2, its own destination index when its old-destination read flag is set, and register 0 when its mask read flag is set. There is no hold when slot 0's scalar destination is valid.
- R5: Each slot has four read flags: vs1, vs2, old destination and mask. When more than 4 of the flags are set across both slots, slot 1 is held and slot 0 may still go.
- R6: A slot is dispatched only when three things hold: its target execution queue's ready for that slot is high, its reorder-buffer ready is high, and, for a load/store micro-op, its load/store map-info ready is high. A queue that is not the target has no effect on the slot.
- R7: For each slot, queue ready, reorder-buffer valid and the target execution queue's valid all equal the dispatch decision. All other queue valids stay low. Map-info valid is raised only for a dispatched load/store micro-op. With no queue valid, all of these outputs are low.
- R8: The unit code is 3 bits and maps to a queue as follows. Codes 0 (ALU) and 1 (compare) go to queue 0. Codes 2 (permute) and 3 (reduction) go to queue 1. Code 4 (multiply) goes to queue 2, code 5 (divide) to queue 3 and code 6 (load/store) to queue 4. Code 7 is never dispatched.
- R9: Slot 0's reorder-buffer address equals the base index supplied by the reorder buffer. Slot 1's address is that base plus one, modulo the buffer size.
- R10: When slot 1 is a compare or reduction micro-op and its first-micro-op flag is low, slot 1's address equals slot 0's address.
- R11: The destination sent to the reorder buffer is the scalar index with the scalar type flag set to 1 when the scalar destination is valid. Otherwise it is the vector destination index with the flag set to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the checks) |
| rst | input | 1 | Synchronous active-high reset |
| uq_valid | input | 2 | Per-slot micro-op valid from the queue |
| uq_ready | output | 2 | Per-slot accept back to the queue |
| sl_dep_pend | input | 2 | Per-slot dependency on an unfinished reorder-buffer result |
| sl_vs1_idx | input | 2x5 | Per-slot first vector source index |
| sl_vs1_rd | input | 2 | Per-slot first vector source read |
| sl_vs2_idx | input | 2x5 | Per-slot second vector source index |
| sl_vs2_rd | input | 2 | Per-slot second vector source read |
| sl_vs3_rd | input | 2 | Per-slot read of the old destination value |
| sl_mask_rd | input | 2 | Per-slot read of mask register 0 |
| sl_vd_idx | input | 2x5 | Per-slot vector destination index |
| sl_vd_wr | input | 2 | Per-slot vector destination written |
| sl_xd_idx | input | 2x5 | Per-slot scalar destination index |
| sl_xd_wr | input | 2 | Per-slot scalar destination valid |
| sl_unit | input | 2x3 | Per-slot unit code |
| s1_first | input | 1 | Slot 1 is the first micro-op of its instruction |
| eq_ready | input | 5x2 | Ready per execution queue per slot |
| eq_valid | output | 5x2 | Valid per execution queue per slot |
| lsmap_ready | input | 2 | Load/store map-info ready per slot |
| lsmap_valid | output | 2 | Load/store map-info valid per slot |
| rob_ready | input | 2 | Reorder-buffer ready per slot |
| rob_valid | output | 2 | Reorder-buffer valid per slot |
| rob_base | input | 3 | Next free reorder-buffer index |
| sl_rob_addr | output | 2x3 | Reorder-buffer address per slot |
| rob_dst_idx | output | 2x5 | Destination index per slot for the reorder buffer |
| rob_dst_scalar | output | 2 | Destination is scalar, per slot |

## Verification
The checks assume that the inputs are steady between clock edges. They also assume that the pending-dependency flags already cover every comparison against the reorder buffer, so the controller never looks at that buffer's contents. Valid is allowed to depend on ready at this boundary. The properties therefore constrain only the combinational relations between the decision, the steering outputs and the inputs of the same cycle. Each stimulus task sets every input after a falling clock edge and samples before the next rising edge, so all values are settled when they are observed. A case that should raise a hold is paired with a near-identical case where the hold should not appear.

// File: rtl/pd_pkg.sv
package pd_pkg;
    localparam int NSLOT  = 2;
    localparam int NQUEUE = 5;

    typedef enum logic [2:0] {
        U_ALU  = 3'd0,
        U_CMP  = 3'd1,
        U_PERM = 3'd2,
        U_RED  = 3'd3,
        U_MUL  = 3'd4,
        U_DIV  = 3'd5,
        U_LDST = 3'd6,
        U_NONE = 3'd7
    } unit_e;

    localparam logic [2:0] Q_ALU = 3'd0;
    localparam logic [2:0] Q_PR  = 3'd1;
    localparam logic [2:0] Q_MUL = 3'd2;
    localparam logic [2:0] Q_DIV = 3'd3;
    localparam logic [2:0] Q_LS  = 3'd4;

    typedef struct packed {
        logic       hit;
        logic [2:0] q;
    } qsel_t;

    function automatic qsel_t queue_of(input logic [2:0] u);
        qsel_t s;
        s.hit = 1'b1;
        case (u)
            U_ALU, U_CMP:  s.q = Q_ALU;
            U_PERM, U_RED: s.q = Q_PR;
            U_MUL:         s.q = Q_MUL;
            U_DIV:         s.q = Q_DIV;
            U_LDST:        s.q = Q_LS;
            default: begin s.hit = 1'b0; s.q = 3'd0; end
        endcase
        return s;
    endfunction

    function automatic logic shares_rob(input logic [2:0] u);
        return (u == U_CMP) || (u == U_RED);
    endfunction

    function automatic logic [2:0] read_count(input logic a, input logic b,
                                              input logic c, input logic d);
        return 3'(a) + 3'(b) + 3'(c) + 3'(d);
    endfunction
endpackage

// File: rtl/pd_pair_hazard.sv
module pd_pair_hazard import pd_pkg::*; #(
    parameter int IDX_W      = 5,
    parameter int READ_PORTS = 4
) (
    input  logic             v0,
    input  logic [IDX_W-1:0] vd0_idx,
    input  logic             vd0_wr,
    input  logic             xd0_wr,
    input  logic [3:0]       rd_flags0,
    input  logic [IDX_W-1:0] s1_vs1,
    input  logic [IDX_W-1:0] s1_vs2,
    input  logic [IDX_W-1:0] s1_vd,
    input  logic [3:0]       rd_flags1,
    output logic             raw1,
    output logic             over_budget
);
    localparam logic [3:0] BUDGET = 4'(READ_PORTS);

    logic       hit_vs1, hit_vs2, hit_vs3, hit_mask;
    logic [3:0] total;

    // rd_flags bit order: 0 vs1, 1 vs2, 2 old destination, 3 mask
    always_comb begin
        hit_vs1  = rd_flags1[0] && (s1_vs1 == vd0_idx);
        hit_vs2  = rd_flags1[1] && (s1_vs2 == vd0_idx);
        hit_vs3  = rd_flags1[2] && (s1_vd  == vd0_idx);
        hit_mask = rd_flags1[3] && (vd0_idx == '0);
        raw1     = v0 && vd0_wr && !xd0_wr &&
                   (hit_vs1 || hit_vs2 || hit_vs3 || hit_mask);
        total    = {1'b0, read_count(rd_flags0[0], rd_flags0[1], rd_flags0[2], rd_flags0[3])}
                 + {1'b0, read_count(rd_flags1[0], rd_flags1[1], rd_flags1[2], rd_flags1[3])};
        over_budget = total > BUDGET;
    end

    // R4: a scalar-writing slot 0 never blocks slot 1
    always_comb begin
        a_r4_scalar_no_block: assert (!(xd0_wr && raw1));
    end
endmodule

// File: rtl/pd_slot_route.sv
module pd_slot_route import pd_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        unit,
    input  logic [NQUEUE-1:0] q_ready,
    input  logic              map_ready,
    input  logic              rob_rdy,
    input  logic              go,
    output logic              ok,
    output logic [NQUEUE-1:0] q_valid,
    output logic              map_valid,
    output logic              rob_vld
);
    qsel_t             sel;
    logic [NQUEUE-1:0] qhot;
    logic              is_ls;

    assign sel = queue_of(unit);

    for (genvar k = 0; k < NQUEUE; k++) begin : g_hot
        assign qhot[k] = sel.hit && (sel.q == 3'(k));
    end

    assign is_ls     = qhot[Q_LS];
    assign ok        = (|(qhot & q_ready)) && rob_rdy && (!is_ls || map_ready);
    assign q_valid   = qhot & {NQUEUE{go}};
    assign map_valid = go && is_ls;
    assign rob_vld   = go;

    a_r7_one_queue: assert property (@(posedge clk) disable iff (rst)
        $onehot0(q_valid));
    a_r6_target_ready: assert property (@(posedge clk) disable iff (rst)
        go |-> (rob_rdy && (|(q_valid & q_ready))));
    a_r8_illegal_unit: assert property (@(posedge clk) disable iff (rst)
        (unit == U_NONE) |-> !go);
endmodule

// File: rtl/pd_rob_alloc.sv
module pd_rob_alloc import pd_pkg::*; #(
    parameter int ROB_AW = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [ROB_AW-1:0]            base,
    input  logic [2:0]                   unit1,
    input  logic                         first1,
    output logic [NSLOT-1:0][ROB_AW-1:0] addr
);
    logic merge;

    assign merge   = shares_rob(unit1) && !first1;
    assign addr[0] = base;
    assign addr[1] = merge ? base : base + ROB_AW'(1);

    a_r10_shared_slot: assert property (@(posedge clk) disable iff (rst)
        ((unit1 == U_RED) && !first1) |-> (addr[1] == addr[0]));
    a_r9_next_slot: assert property (@(posedge clk) disable iff (rst)
        (unit1 == U_MUL) |-> (addr[1] != addr[0]));
endmodule

// File: rtl/pair_dispatch.sv
module pair_dispatch import pd_pkg::*; #(
    parameter int IDX_W      = 5,
    parameter int ROB_AW     = 3,
    parameter int READ_PORTS = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NSLOT-1:0]              uq_valid,
    output logic [NSLOT-1:0]              uq_ready,
    input  logic [NSLOT-1:0]              sl_dep_pend,
    input  logic [NSLOT-1:0][IDX_W-1:0]   sl_vs1_idx,
    input  logic [NSLOT-1:0]              sl_vs1_rd,
    input  logic [NSLOT-1:0][IDX_W-1:0]   sl_vs2_idx,
    input  logic [NSLOT-1:0]              sl_vs2_rd,
    input  logic [NSLOT-1:0]              sl_vs3_rd,
    input  logic [NSLOT-1:0]              sl_mask_rd,
    input  logic [NSLOT-1:0][IDX_W-1:0]   sl_vd_idx,
    input  logic [NSLOT-1:0]              sl_vd_wr,
    input  logic [NSLOT-1:0][IDX_W-1:0]   sl_xd_idx,
    input  logic [NSLOT-1:0]              sl_xd_wr,
    input  logic [NSLOT-1:0][2:0]         sl_unit,
    input  logic                          s1_first,
    input  logic [NQUEUE-1:0][NSLOT-1:0]  eq_ready,
    output logic [NQUEUE-1:0][NSLOT-1:0]  eq_valid,
    input  logic [NSLOT-1:0]              lsmap_ready,
    output logic [NSLOT-1:0]              lsmap_valid,
    input  logic [NSLOT-1:0]              rob_ready,
    output logic [NSLOT-1:0]              rob_valid,
    input  logic [ROB_AW-1:0]             rob_base,
    output logic [NSLOT-1:0][ROB_AW-1:0]  sl_rob_addr,
    output logic [NSLOT-1:0][IDX_W-1:0]   rob_dst_idx,
    output logic [NSLOT-1:0]              rob_dst_scalar
);
    logic [NSLOT-1:0]       ok, go;
    logic [NSLOT-1:0][3:0]  rd_flags;
    logic                   raw1, over_budget;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic [NQUEUE-1:0] rdy_col, vld_col;

        assign rd_flags[s] = {sl_mask_rd[s], sl_vs3_rd[s], sl_vs2_rd[s], sl_vs1_rd[s]};

        for (genvar q = 0; q < NQUEUE; q++) begin : g_col
            assign rdy_col[q]     = eq_ready[q][s];
            assign eq_valid[q][s] = vld_col[q];
        end

        pd_slot_route u_route (
            .clk       (clk),
            .rst       (rst),
            .unit      (sl_unit[s]),
            .q_ready   (rdy_col),
            .map_ready (lsmap_ready[s]),
            .rob_rdy   (rob_ready[s]),
            .go        (go[s]),
            .ok        (ok[s]),
            .q_valid   (vld_col),
            .map_valid (lsmap_valid[s]),
            .rob_vld   (rob_valid[s])
        );

        assign rob_dst_idx[s]    = sl_xd_wr[s] ? sl_xd_idx[s] : sl_vd_idx[s];
        assign rob_dst_scalar[s] = sl_xd_wr[s];
    end

    pd_pair_hazard #(.IDX_W(IDX_W), .READ_PORTS(READ_PORTS)) u_hazard (
        .v0          (uq_valid[0]),
        .vd0_idx     (sl_vd_idx[0]),
        .vd0_wr      (sl_vd_wr[0]),
        .xd0_wr      (sl_xd_wr[0]),
        .rd_flags0   (rd_flags[0]),
        .s1_vs1      (sl_vs1_idx[1]),
        .s1_vs2      (sl_vs2_idx[1]),
        .s1_vd       (sl_vd_idx[1]),
        .rd_flags1   (rd_flags[1]),
        .raw1        (raw1),
        .over_budget (over_budget)
    );

    pd_rob_alloc #(.ROB_AW(ROB_AW)) u_alloc (
        .clk    (clk),
        .rst    (rst),
        .base   (rob_base),
        .unit1  (sl_unit[1]),
        .first1 (s1_first),
        .addr   (sl_rob_addr)
    );

    always_comb begin
        go[0] = uq_valid[0] && !sl_dep_pend[0] && ok[0];
        go[1] = go[0] && uq_valid[1] && !sl_dep_pend[1] && ok[1] &&
                !raw1 && !over_budget;
    end

    assign uq_ready = go;

    a_r1_in_order: assert property (@(posedge clk) disable iff (rst)
        uq_ready[1] |-> uq_ready[0]);
    a_r2_slot0_hold: assert property (@(posedge clk) disable iff (rst)
        (sl_dep_pend[0] || !uq_valid[0]) |-> (uq_ready == '0));
    a_r3_slot1_hold: assert property (@(posedge clk) disable iff (rst)
        sl_dep_pend[1] |-> !uq_ready[1]);
    a_r5_read_budget: assert property (@(posedge clk) disable iff (rst)
        uq_ready[1] |-> ($countones({rd_flags[1], rd_flags[0]}) <= READ_PORTS));
    a_r7_rob_follows: assert property (@(posedge clk) disable iff (rst)
        rob_valid == uq_ready);
    a_r11_dst_scalar: assert property (@(posedge clk) disable iff (rst)
        sl_xd_wr[0] |-> (rob_dst_idx[0] == sl_xd_idx[0]));
endmodule

// File: tb/pair_dispatch_test.sv
module pair_dispatch_test;
    logic clk = 1'b0;
    logic rst;
    always #5 clk = ~clk;

    logic [1:0]       uq_valid, uq_ready, sl_dep_pend;
    logic [1:0][4:0]  sl_vs1_idx, sl_vs2_idx, sl_vd_idx, sl_xd_idx;
    logic [1:0]       sl_vs1_rd, sl_vs2_rd, sl_vs3_rd, sl_mask_rd, sl_vd_wr, sl_xd_wr;
    logic [1:0][2:0]  sl_unit;
    logic             s1_first;
    logic [4:0][1:0]  eq_ready, eq_valid;
    logic [1:0]       lsmap_ready, lsmap_valid, rob_ready, rob_valid;
    logic [2:0]       rob_base;
    logic [1:0][2:0]  sl_rob_addr;
    logic [1:0][4:0]  rob_dst_idx;
    logic [1:0]       rob_dst_scalar;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    pair_dispatch uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic defaults();
        @(negedge clk);
        uq_valid = 2'b11; sl_dep_pend = 2'b00;
        sl_vs1_idx[0] = 5'd1; sl_vs2_idx[0] = 5'd2; sl_vd_idx[0] = 5'd10; sl_xd_idx[0] = 5'd20;
        sl_vs1_idx[1] = 5'd3; sl_vs2_idx[1] = 5'd4; sl_vd_idx[1] = 5'd11; sl_xd_idx[1] = 5'd21;
        sl_vs1_rd = 2'b11; sl_vs2_rd = 2'b11; sl_vs3_rd = 2'b00; sl_mask_rd = 2'b00;
        sl_vd_wr = 2'b11; sl_xd_wr = 2'b00;
        sl_unit[0] = 3'd0; sl_unit[1] = 3'd4; s1_first = 1'b1;
        eq_ready = '1; lsmap_ready = 2'b11; rob_ready = 2'b11; rob_base = 3'd5;
    endtask

    task automatic settle(); #2; endtask

    task automatic t_idle();
        defaults(); uq_valid = 2'b00; settle();
        chk("R7 idle ready", 32'(uq_ready), 0);
        chk("R7 idle eq_valid", 32'(eq_valid), 0);
        chk("R7 idle rob_valid", 32'(rob_valid), 0);
        uq_valid = 2'b10; settle();
        chk("R2 slot0 invalid", 32'(uq_ready), 0);
    endtask

    task automatic t_pair();
        defaults(); settle();
        chk("R1 pair ready", 32'(uq_ready), 3);
        chk("R7 pair eq_valid", 32'(eq_valid), 32'h021);
        chk("R7 pair rob_valid", 32'(rob_valid), 3);
        chk("R7 pair no map", 32'(lsmap_valid), 0);
        chk("R9 addr0", 32'(sl_rob_addr[0]), 5);
        chk("R9 addr1", 32'(sl_rob_addr[1]), 6);
    endtask

    task automatic t_dep();
        defaults(); sl_dep_pend = 2'b01; settle();
        chk("R2 slot0 dep", 32'(uq_ready), 0);
        chk("R1 slot0 dep rob", 32'(rob_valid), 0);
        sl_dep_pend = 2'b10; settle();
        chk("R3 slot1 dep", 32'(uq_ready), 1);
    endtask

    task automatic t_raw();
        defaults(); sl_vs2_idx[1] = 5'd10; settle();
        chk("R4 vs2 match", 32'(uq_ready), 1);
        sl_xd_wr[0] = 1'b1; settle();
        chk("R4 scalar writer", 32'(uq_ready), 3);
        defaults(); sl_vs1_idx[1] = 5'd10; settle();
        chk("R4 vs1 match", 32'(uq_ready), 1);
        defaults(); sl_vs2_rd[1] = 1'b0; sl_vd_idx[1] = 5'd10; sl_vs3_rd[1] = 1'b1; settle();
        chk("R4 old dest match", 32'(uq_ready), 1);
        defaults(); sl_vs2_rd[1] = 1'b0; sl_vd_idx[0] = 5'd0; settle();
        chk("R4 vd0 zero no mask", 32'(uq_ready), 3);
        sl_mask_rd[1] = 1'b1; settle();
        chk("R4 mask match", 32'(uq_ready), 1);
        sl_vd_wr[0] = 1'b0; settle();
        chk("R4 no vector write", 32'(uq_ready), 3);
    endtask

    task automatic t_budget();
        defaults(); sl_vs3_rd[0] = 1'b1; settle();
        chk("R5 five reads", 32'(uq_ready), 1);
        chk("R5 five reads rob", 32'(rob_valid), 1);
        sl_vs1_rd[1] = 1'b0; settle();
        chk("R5 four reads", 32'(uq_ready), 3);
    endtask

    task automatic t_ready();
        defaults(); eq_ready[0][0] = 1'b0; settle();
        chk("R6 own queue busy", 32'(uq_ready), 0);
        defaults(); eq_ready[2][0] = 1'b0; eq_ready[0][1] = 1'b0; settle();
        chk("R6 other queue busy", 32'(uq_ready), 3);
        defaults(); rob_ready[1] = 1'b0; settle();
        chk("R6 rob busy slot1", 32'(uq_ready), 1);
        defaults(); sl_unit[0] = 3'd6; lsmap_ready[0] = 1'b0; settle();
        chk("R6 map busy", 32'(uq_ready), 0);
        chk("R6 map busy valid", 32'(lsmap_valid), 0);
        lsmap_ready[0] = 1'b1; settle();
        chk("R7 ldst ready", 32'(uq_ready), 3);
        chk("R7 ldst map", 32'(lsmap_valid), 1);
        chk("R8 ldst queue", 32'(eq_valid), 32'h120);
    endtask

    task automatic t_units();
        defaults(); sl_unit[0] = 3'd1; sl_unit[1] = 3'd5; settle();
        chk("R8 cmp div", 32'(eq_valid), 32'h081);
        sl_unit[0] = 3'd3; sl_unit[1] = 3'd2; settle();
        chk("R8 red perm", 32'(eq_valid), 32'h00C);
        sl_unit[0] = 3'd7; settle();
        chk("R8 code 7", 32'(uq_ready), 0);
        chk("R8 code 7 eq", 32'(eq_valid), 0);
    endtask

    task automatic t_rob();
        defaults(); rob_base = 3'd7; settle();
        chk("R9 wrap", 32'(sl_rob_addr[1]), 0);
        sl_unit[1] = 3'd3; s1_first = 1'b0; settle();
        chk("R10 red share", 32'(sl_rob_addr[1]), 7);
        sl_unit[1] = 3'd1; settle();
        chk("R10 cmp share", 32'(sl_rob_addr[1]), 7);
        s1_first = 1'b1; settle();
        chk("R10 cmp first", 32'(sl_rob_addr[1]), 0);
        sl_unit[1] = 3'd0; s1_first = 1'b0; settle();
        chk("R10 alu no share", 32'(sl_rob_addr[1]), 0);
    endtask

    task automatic t_dst();
        defaults(); sl_xd_wr[0] = 1'b1; sl_xd_idx[0] = 5'd17; settle();
        chk("R11 scalar idx", 32'(rob_dst_idx[0]), 17);
        chk("R11 scalar flag", 32'(rob_dst_scalar), 1);
        chk("R11 vector idx", 32'(rob_dst_idx[1]), 11);
    endtask

    initial begin
        rst = 1'b1;
        defaults();
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_idle();
        t_pair();
        t_dep();
        t_raw();
        t_budget();
        t_ready();
        t_units();
        t_rob();
        t_dst();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule